// File: doc/BRIEF.md
# Receive Frame Length Checker

The block watches a byte-wide receive stream and, for every frame, measures its length from the first destination address byte through the last FCS byte. It compares that length against a programmable ceiling and against the 64-octet floor of a legal frame. Frames that carry one or two 802.1Q-style tags are given extra room above the ceiling, 4 octets for a single tag and 8 for a double tag, but only while detection of that tag depth is switched on. A second instance with its own ceiling serves the transmit direction, under the same rule.

Frames arrive as `in_valid` beats with `in_sop` on the first byte and `in_eop` on the last. Idle beats (`in_valid` low) may appear anywhere and are not counted. On the beat that carries `in_eop`, the block presents a one-cycle status: the measured length, an oversized flag, an undersized flag and the tag code it used. A small write port sets the ceiling and the two tag enables. The block stores no data, checks no FCS and keeps no statistics.

The control is a three-state machine. `ST_IDLE` (outside any frame) moves to `ST_HEAD` on a start beat without an end. `ST_HEAD` (bytes 0..17, where the tags are read) moves to `ST_BODY` once byte 17 has been taken. `ST_BODY` (remaining payload) holds until the end. Every state returns to `ST_IDLE` on an end beat. A start beat in `ST_HEAD` or `ST_BODY` goes to `ST_HEAD` (restart).

Top module: `frame_len_checker`

## Requirements
- R1: After reset, no status is presented, the ceiling is 1518 octets and both tag enables are clear.
- R2: `st_valid` is high for exactly the accepted beat with `in_eop`, and `st_len` equals the number of valid beats from the start beat through the end beat inclusive. A frame of a single beat with both markers has length 1.
- R3: An untagged frame (tag code 0) is flagged oversized exactly when its length exceeds the ceiling.
- R4: A frame is flagged undersized exactly when its length is below 64 octets, whatever its tags.
- R5: With the single-tag enable set (write address 1, data bit 0), a frame whose bytes 12..13 are 0x81, 0x00 reports tag code 1 and is oversized only when its length exceeds the ceiling plus 4.
- R6: With the double-tag enable set (write address 1, data bit 1), a frame whose bytes 12..13 are 0x88A8 or 0x8100 and whose bytes 16..17 are 0x8100 reports tag code 2 and is oversized only when its length exceeds the ceiling plus 8. This takes priority over R5.
- R7: A tag shape whose enable is clear gets no allowance. A 0x88A8 outer tag with the double-tag enable clear reports code 0. A 0x8100/0x8100 frame with only the single-tag enable set reports code 1 and gets 4 octets.
- R8: A start beat inside a frame abandons that frame without status and begins a new one. Valid beats outside a frame, without a start marker, are ignored and produce no status.
- R9: A write to address 0 sets the ceiling from `cfg_wdata`, and a write to address 1 sets the enables. Both take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0: ceiling, 1: tag enables |
| cfg_wdata | input | LEN_W | Write data |
| in_valid | input | 1 | Byte beat valid |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| st_valid | output | 1 | Status strobe, coincident with the end beat |
| st_len | output | LEN_W | Measured frame length in octets |
| st_oversize | output | 1 | Length exceeds ceiling plus allowance |
| st_undersize | output | 1 | Length below 64 |
| st_tag | output | 2 | 0 untagged, 1 single tag, 2 double tag |

## Verification
On every cycle, the bound checker confirms the following:
- Status appears only on a valid end beat.
- A one-beat frame reports length 1.
- The undersize flag follows the 64-octet floor.
- For each tag code, the oversize flag follows the ceiling plus that code's allowance. The checker tracks the ceiling from the write port itself.
- A nonzero tag code only appears while its enable is set.
- The flags stay low between status strobes.

Some behaviours can only be shown by the bench's scenarios against its byte-level model:
- Tag bytes at offsets 12..13 and 16..17 are recognised correctly.
- Idle gaps are not counted.
- Aborted frames and stray beats produce no status.
- The reset defaults hold.
- The fallback from double to single classification works.

// File: rtl/flc_pkg.sv
package flc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_BODY = 2'd2
    } flc_state_e;

    typedef enum logic [1:0] {
        TAG_NONE   = 2'd0,
        TAG_SINGLE = 2'd1,
        TAG_DOUBLE = 2'd2
    } flc_tag_e;

    localparam logic [15:0] TPID_CUST  = 16'h8100;
    localparam logic [15:0] TPID_SERV  = 16'h88A8;
    localparam int          OFS_OUTER  = 12;
    localparam int          OFS_INNER  = 16;
    localparam int          HDR_BYTES  = 18;
    localparam int          MIN_FRAME  = 64;
    localparam int          ALLOW_ONE  = 4;
    localparam int          ALLOW_TWO  = 8;

endpackage

// File: rtl/flc_cfg_regs.sv
module flc_cfg_regs #(
    parameter int LEN_W       = 16,
    parameter int DEF_MAX_LEN = 1518
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_addr,
    input  logic [LEN_W-1:0] cfg_wdata,
    output logic [LEN_W-1:0] max_len,
    output logic             single_en,
    output logic             double_en
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_len   <= LEN_W'(DEF_MAX_LEN);
            single_en <= 1'b0;
            double_en <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_addr == 1'b0) begin
                max_len <= cfg_wdata;
            end else begin
                single_en <= cfg_wdata[0];
                double_en <= cfg_wdata[1];
            end
        end
    end
endmodule

// File: rtl/flc_len_counter.sv
module flc_len_counter #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             sop,
    output logic [LEN_W-1:0] cur_len
);
    localparam logic [LEN_W-1:0] LEN_SAT = {LEN_W{1'b1}};

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] base;

    always_comb begin
        base    = sop ? '0 : cnt_q;
        cur_len = (base == LEN_SAT) ? base : base + LEN_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (beat) begin
            cnt_q <= cur_len;
        end
    end
endmodule

// File: rtl/flc_tag_classifier.sv
module flc_tag_classifier
    import flc_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_beat,
    input  logic             sop,
    input  logic [LEN_W-1:0] idx,
    input  logic [7:0]       data,
    output logic             outer_cust,
    output logic             outer_serv,
    output logic             inner_cust
);
    logic [7:0] hi_outer_q, hi_inner_q;
    logic       outer_cust_q, outer_serv_q, inner_cust_q;
    logic       at_outer_lo, at_inner_lo;

    always_comb begin
        at_outer_lo = hdr_beat && (idx == LEN_W'(OFS_OUTER + 1));
        at_inner_lo = hdr_beat && (idx == LEN_W'(OFS_INNER + 1));
        outer_cust  = (!sop && outer_cust_q) ||
                      (at_outer_lo && ({hi_outer_q, data} == TPID_CUST));
        outer_serv  = (!sop && outer_serv_q) ||
                      (at_outer_lo && ({hi_outer_q, data} == TPID_SERV));
        inner_cust  = (!sop && inner_cust_q) ||
                      (at_inner_lo && ({hi_inner_q, data} == TPID_CUST));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_outer_q   <= '0;
            hi_inner_q   <= '0;
            outer_cust_q <= 1'b0;
            outer_serv_q <= 1'b0;
            inner_cust_q <= 1'b0;
        end else if (hdr_beat) begin
            if (idx == LEN_W'(OFS_OUTER)) hi_outer_q <= data;
            if (idx == LEN_W'(OFS_INNER)) hi_inner_q <= data;
            outer_cust_q <= outer_cust;
            outer_serv_q <= outer_serv;
            inner_cust_q <= inner_cust;
        end
    end
endmodule

// File: rtl/frame_len_checker.sv
module frame_len_checker
    import flc_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int DEF_MAX_LEN = 1518
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_addr,
    input  logic [LEN_W-1:0] cfg_wdata,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [7:0]       in_data,
    output logic             st_valid,
    output logic [LEN_W-1:0] st_len,
    output logic             st_oversize,
    output logic             st_undersize,
    output logic [1:0]       st_tag
);
    localparam int LIM_W = LEN_W + 1;

    logic [LEN_W-1:0] max_len;
    logic             single_en, double_en;
    logic [LEN_W-1:0] cur_len;
    logic             outer_cust, outer_serv, inner_cust;
    logic             beat, hdr_beat;
    flc_state_e       state_q, state_d;
    flc_tag_e         kind;
    logic [LIM_W-1:0] limit;

    assign beat     = in_valid && (in_sop || (state_q != ST_IDLE));
    assign hdr_beat = beat && (in_sop || (state_q == ST_HEAD));

    flc_cfg_regs #(.LEN_W(LEN_W), .DEF_MAX_LEN(DEF_MAX_LEN)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .max_len   (max_len),
        .single_en (single_en),
        .double_en (double_en)
    );

    flc_len_counter #(.LEN_W(LEN_W)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat    (beat),
        .sop     (in_sop),
        .cur_len (cur_len)
    );

    flc_tag_classifier #(.LEN_W(LEN_W)) u_tag (
        .clk        (clk),
        .rst_n      (rst_n),
        .hdr_beat   (hdr_beat),
        .sop        (in_sop),
        .idx        (cur_len - LEN_W'(1)),
        .data       (in_data),
        .outer_cust (outer_cust),
        .outer_serv (outer_serv),
        .inner_cust (inner_cust)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (beat && !in_eop) state_d = ST_HEAD;
            end
            ST_HEAD: begin
                if (beat) begin
                    if (in_eop)                         state_d = ST_IDLE;
                    else if (in_sop)                    state_d = ST_HEAD;
                    else if (cur_len >= LEN_W'(HDR_BYTES)) state_d = ST_BODY;
                end
            end
            ST_BODY: begin
                if (beat) begin
                    if (in_eop)      state_d = ST_IDLE;
                    else if (in_sop) state_d = ST_HEAD;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        kind = TAG_NONE;
        if (double_en && (outer_cust || outer_serv) && inner_cust) kind = TAG_DOUBLE;
        else if (single_en && outer_cust)                          kind = TAG_SINGLE;

        limit = LIM_W'(max_len);
        unique case (kind)
            TAG_SINGLE: limit = LIM_W'(max_len) + LIM_W'(ALLOW_ONE);
            TAG_DOUBLE: limit = LIM_W'(max_len) + LIM_W'(ALLOW_TWO);
            default:    limit = LIM_W'(max_len);
        endcase

        st_valid     = beat && in_eop;
        st_len       = st_valid ? cur_len : '0;
        st_oversize  = st_valid && (LIM_W'(cur_len) > limit);
        st_undersize = st_valid && (cur_len < LEN_W'(MIN_FRAME));
        st_tag       = st_valid ? kind : TAG_NONE;
    end
endmodule

// File: rtl/flc_checker.sv
module flc_checker
    import flc_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int DEF_MAX_LEN = 1518
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             cfg_addr,
    input logic [LEN_W-1:0] cfg_wdata,
    input logic             in_valid,
    input logic             in_sop,
    input logic             in_eop,
    input logic             st_valid,
    input logic [LEN_W-1:0] st_len,
    input logic             st_oversize,
    input logic             st_undersize,
    input logic [1:0]       st_tag
);
    logic [LEN_W-1:0] sh_max;
    logic             sh_one, sh_two;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_max <= LEN_W'(DEF_MAX_LEN);
            sh_one <= 1'b0;
            sh_two <= 1'b0;
        end else if (cfg_we) begin
            if (!cfg_addr) sh_max <= cfg_wdata;
            else           {sh_two, sh_one} <= cfg_wdata[1:0];
        end
    end

    a_r2_status_on_eop: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (in_valid && in_eop));
    a_r2_one_beat_len: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && in_sop) |-> (st_len == LEN_W'(1)));
    a_r3_untagged_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_tag == 2'd0) |-> (st_oversize == ((LEN_W+1)'(st_len) > (LEN_W+1)'(sh_max))));
    a_r4_undersize: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_undersize == (st_len < LEN_W'(MIN_FRAME))));
    a_r5_single_allow: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_tag == 2'd1) |-> (sh_one &&
            (st_oversize == ((LEN_W+1)'(st_len) > (LEN_W+1)'(sh_max) + (LEN_W+1)'(ALLOW_ONE)))));
    a_r6_double_allow: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_tag == 2'd2) |-> (sh_two &&
            (st_oversize == ((LEN_W+1)'(st_len) > (LEN_W+1)'(sh_max) + (LEN_W+1)'(ALLOW_TWO)))));
    a_r7_tag_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        st_tag != 2'd3);
    a_r8_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |-> (!st_oversize && !st_undersize && st_tag == 2'd0));
endmodule

bind frame_len_checker flc_checker #(.LEN_W(LEN_W), .DEF_MAX_LEN(DEF_MAX_LEN)) u_flc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .in_valid     (in_valid),
    .in_sop       (in_sop),
    .in_eop       (in_eop),
    .st_valid     (st_valid),
    .st_len       (st_len),
    .st_oversize  (st_oversize),
    .st_undersize (st_undersize),
    .st_tag       (st_tag)
);

// File: tb/frame_len_checker_bench.sv
module frame_len_checker_bench;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_addr = 1'b0;
    logic [LEN_W-1:0] cfg_wdata = '0;
    logic             in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]       in_data = '0;
    logic             st_valid, st_oversize, st_undersize;
    logic [LEN_W-1:0] st_len;
    logic [1:0]       st_tag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int m_max = 1518;
    bit m_one = 0, m_two = 0;
    bit m_in  = 0;
    int m_cnt = 0;
    int m_hdr [18];

    always #5 clk = ~clk;

    frame_len_checker u_frame_len_checker (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .st_valid(st_valid), .st_len(st_len), .st_oversize(st_oversize),
        .st_undersize(st_undersize), .st_tag(st_tag)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic compare(input string req);
        int h [18];
        int len, outer, inner, allow, tag;
        bit ev;
        ev = in_valid && (in_sop || m_in) && in_eop;
        chk(req, "st_valid", st_valid, ev);
        if (ev) begin
            for (int k = 0; k < 18; k++) h[k] = in_sop ? 0 : m_hdr[k];
            len = in_sop ? 1 : m_cnt + 1;
            if (len <= 18) h[len-1] = in_data;
            outer = (len >= 14) ? (h[12] * 256 + h[13]) : 0;
            inner = (len >= 18) ? (h[16] * 256 + h[17]) : 0;
            tag = 0; allow = 0;
            if (m_two && (outer == 'h8100 || outer == 'h88A8) && inner == 'h8100) begin
                tag = 2; allow = 8;
            end else if (m_one && outer == 'h8100) begin
                tag = 1; allow = 4;
            end
            chk(req, "st_len", st_len, len);
            chk(req, "st_oversize", st_oversize, int'(len > m_max + allow));
            chk(req, "st_undersize", st_undersize, int'(len < 64));
            chk(req, "st_tag", st_tag, tag);
        end
    endtask

    task automatic drive(input bit v, input bit s, input bit e, input logic [7:0] d, input string req);
        @(negedge clk);
        in_valid = v; in_sop = s; in_eop = e; in_data = d;
        #1;
        compare(req);
        @(posedge clk);
        if (v) begin
            if (s) begin
                for (int k = 0; k < 18; k++) m_hdr[k] = 0;
                m_hdr[0] = d; m_cnt = 1; m_in = !e;
            end else if (m_in) begin
                if (m_cnt < 18) m_hdr[m_cnt] = d;
                m_cnt++;
                if (e) m_in = 0;
            end
        end
    endtask

    task automatic wr_cfg(input bit a, input int val, input string req);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = LEN_W'(val);
        drive(0, 0, 0, 8'h00, req);
        if (!a) m_max = val;
        else begin m_one = val[0]; m_two = val[1]; end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input int len, input logic [15:0] outer, input logic [15:0] inner,
                        input bit close, input int gap_at, input string req);
        for (int i = 0; i < len; i++) begin
            logic [7:0] d;
            d = (i == 12) ? outer[15:8] : (i == 13) ? outer[7:0] :
                (i == 16) ? inner[15:8] : (i == 17) ? inner[7:0] : 8'(i);
            drive(1, i == 0, close && (i == len - 1), d, req);
            if (i == gap_at) drive(0, 0, 0, 8'hEE, req);
        end
        drive(0, 0, 0, 8'h00, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1", "st_valid after reset", st_valid, 0);
        // R1: defaults 1518, tags off
        send(1518, 16'h0800, 16'h0000, 1, -1, "R1");
        send(1519, 16'h0800, 16'h0000, 1, -1, "R1");
        send(1520, 16'h8100, 16'h0000, 1, -1, "R1");
        // R9: program ceiling
        wr_cfg(0, 100, "R9");
        send(100, 16'h0800, 16'h0000, 1, -1, "R3");
        send(101, 16'h0800, 16'h0000, 1, -1, "R3");
        send(63, 16'h0800, 16'h0000, 1, -1, "R4");
        send(64, 16'h0800, 16'h0000, 1, 30, "R4");
        // R7: tags disabled, no allowance
        send(104, 16'h8100, 16'h0800, 1, -1, "R7");
        send(108, 16'h88A8, 16'h8100, 1, -1, "R7");
        wr_cfg(1, 1, "R9");
        send(104, 16'h8100, 16'h0800, 1, 5, "R5");
        send(105, 16'h8100, 16'h0800, 1, -1, "R5");
        send(14, 16'h8100, 16'h0000, 1, -1, "R5");
        send(108, 16'h88A8, 16'h8100, 1, -1, "R7");
        send(108, 16'h8100, 16'h8100, 1, -1, "R7");
        wr_cfg(1, 3, "R9");
        send(108, 16'h88A8, 16'h8100, 1, 16, "R6");
        send(109, 16'h88A8, 16'h8100, 1, -1, "R6");
        send(108, 16'h8100, 16'h8100, 1, -1, "R6");
        send(18, 16'h88A8, 16'h8100, 1, -1, "R6");
        send(104, 16'h8100, 16'h0800, 1, -1, "R6");
        wr_cfg(1, 2, "R9");
        send(108, 16'h8100, 16'h0800, 1, -1, "R7");
        // R8: abort, stray beats, one-beat frame
        send(40, 16'h8100, 16'h0000, 0, -1, "R8");
        send(70, 16'h0800, 16'h0000, 1, -1, "R8");
        drive(1, 0, 1, 8'h55, "R8");
        drive(1, 0, 0, 8'h56, "R8");
        drive(1, 1, 1, 8'h57, "R2");
        drive(0, 0, 0, 8'h00, "R2");
        send(20, 16'h0800, 16'h0000, 0, -1, "R8");
        send(12, 16'h0800, 16'h0000, 1, 3, "R8");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule